// File: doc/BRIEF.md
# Parallel Code-Memory Programming Controller

This block is the byte-parallel programming engine for an on-chip code memory. An external programmer presents an address, a data byte, a four-line mode code, a high-voltage-enable level and an active-low program strobe. The block decodes the operation from these inputs and carries it out. The operations are: program a code byte, verify-read a code byte, set one of two protection bits, erase the whole array, or read the fixed identification bytes. Byte and lock writes are self-timed once started, and a ready/busy output reports progress. While a byte write is pending, a verify read of that byte returns the top data bit inverted, so the programmer can poll for completion.

The storage is modelled as a register array of `2**ADDR_W` bytes. Write and erase durations are parameters counted in clock cycles; the defaults are 1.5 ms and 10 ms at 100 MHz. A full-size part uses `ADDR_W = 13`. The array reads all ones after reset, which models an erased part. Programming can only clear bits, and only an erase sets them back to one. Inputs are treated as synchronous to `clk_i`.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset every byte reads FFh, `ready_o` is 1, both protection bits are clear and `data_oe_o` is 0.
- R2: A rising edge on `prog_ni` while mode is 0001b (program byte), `hv_en_i` is 1 and the block is ready starts a write. The byte at `addr_i` becomes the bitwise AND of its old value and `data_i`.
- R3: After a write or lock write is accepted, `ready_o` reads 0 for exactly `WRITE_CYC` cycles. It goes low in the first cycle after the clock edge that sees the strobe rise.
- R4: While a byte write is pending, a verify read (mode 0010b) of that address returns the written byte with bit 7 inverted. After completion the read returns the true stored value.
- R5: With mode 1000b (erase) and `hv_en_i` = 1, holding `prog_ni` low for `ERASE_CYC` consecutive clock edges sets every byte to FFh and clears both protection bits. `ready_o` is 0 while the hold is counting. A shorter hold changes nothing.
- R6: With mode 1100b (identify), addresses 030h, 031h and 032h return 1Eh, 62h and FFh. Every other address returns FFh, whatever the array holds.
- R7: A lock write with mode 0100b sets protection bit 1. After that, program-byte strobes are ignored: `ready_o` stays 1 and the array is unchanged.
- R8: A lock write with mode 0101b sets protection bit 2. After that, verify reads return FFh, while identify reads still return their bytes.
- R9: The block ignores a strobe that rises while busy, a strobe with `hv_en_i` = 0, and a strobe with any undefined mode code. None of these alters the array or `ready_o`.
- R10: `data_o` and `data_oe_o` are registered, valid one clock after the inputs change. `data_oe_o` is 1 only for verify or identify modes with `prog_ni` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Data byte to program |
| mode_i | input | 4 | Operation select code |
| hv_en_i | input | 1 | Programming voltage present |
| prog_ni | input | 1 | Program strobe, active low |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data drive enable |
| ready_o | output | 1 | 1 = ready, 0 = busy |

## Verification
Read data is due one clock after mode and address are set. The bench changes inputs on falling edges and samples at the next falling edge, with exactly one rising edge between them. A write starts at the first rising edge after the strobe rises. The bench therefore counts falling-edge samples of `ready_o` low over a fixed window and expects exactly `WRITE_CYC` of them, or zero for a strobe that should be ignored. An erase counts rising edges seen with the strobe held low: the bench holds it for `ERASE_CYC` and for `ERASE_CYC-1` edges, and reads the array back after each hold.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_READ, OP_LOCK1, OP_LOCK2, OP_ERASE, OP_SIG
  } fp_op_e;

  typedef enum logic [1:0] {PK_CODE, PK_LOCK1, PK_LOCK2} fp_kind_e;

  localparam logic [3:0] MODE_WRITE = 4'b0001;
  localparam logic [3:0] MODE_READ  = 4'b0010;
  localparam logic [3:0] MODE_LOCK1 = 4'b0100;
  localparam logic [3:0] MODE_LOCK2 = 4'b0101;
  localparam logic [3:0] MODE_ERASE = 4'b1000;
  localparam logic [3:0] MODE_SIG   = 4'b1100;

  localparam int SIG_BASE = 'h30;

  function automatic logic [7:0] sig_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h1E;
      2'd1:    return 8'h62;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/fp_mode_decode.sv
module fp_mode_decode
  import flash_prog_pkg::*;
(
  input  logic [3:0] mode_i,
  output fp_op_e     op_o
);
  always_comb begin
    case (mode_i)
      MODE_WRITE: op_o = OP_WRITE;
      MODE_READ:  op_o = OP_READ;
      MODE_LOCK1: op_o = OP_LOCK1;
      MODE_LOCK2: op_o = OP_LOCK2;
      MODE_ERASE: op_o = OP_ERASE;
      MODE_SIG:   op_o = OP_SIG;
      default:    op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/fp_seq_timer.sv
module fp_seq_timer
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WRITE_CYC = 150000,
  parameter int ERASE_CYC = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fp_op_e            op_i,
  input  logic              hv_en_i,
  input  logic              prog_ni,
  input  logic              lock1_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              wr_commit_o,
  output logic              lock1_commit_o,
  output logic              lock2_commit_o,
  output logic              erase_commit_o,
  output logic              busy_o,
  output logic              pend_code_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [7:0]        pend_data_o,
  output logic              ready_o
);
  localparam int WC_W = $clog2(WRITE_CYC + 1);
  localparam int EC_W = $clog2(ERASE_CYC + 1);

  logic              prog_q;
  logic              busy_q;
  logic [WC_W-1:0]   cnt_q;
  fp_kind_e          kind_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [7:0]        pend_data_q;
  logic [EC_W-1:0]   hold_cnt_q;
  logic              erase_done_q;

  logic rise, start, hold, last;

  assign rise  = prog_ni & ~prog_q;
  assign start = rise & hv_en_i & ~busy_q &
                 ((op_i == OP_WRITE && !lock1_i) || op_i == OP_LOCK1 || op_i == OP_LOCK2);
  assign last  = busy_q && cnt_q == '0;
  assign hold  = ~prog_ni & hv_en_i & ~busy_q & (op_i == OP_ERASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q      <= 1'b1;
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      kind_q      <= PK_CODE;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      prog_q <= prog_ni;
      if (start) begin
        busy_q      <= 1'b1;
        cnt_q       <= WC_W'(WRITE_CYC - 1);
        pend_addr_q <= addr_i;
        pend_data_q <= data_i;
        kind_q      <= (op_i == OP_LOCK1) ? PK_LOCK1 :
                       (op_i == OP_LOCK2) ? PK_LOCK2 : PK_CODE;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  // erase needs the strobe held low for ERASE_CYC edges; fires once per hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt_q   <= '0;
      erase_done_q <= 1'b0;
    end else if (!hold) begin
      hold_cnt_q   <= '0;
      erase_done_q <= 1'b0;
    end else if (!erase_done_q) begin
      if (erase_commit_o) begin
        hold_cnt_q   <= '0;
        erase_done_q <= 1'b1;
      end else begin
        hold_cnt_q <= hold_cnt_q + 1'b1;
      end
    end
  end

  assign erase_commit_o = hold && !erase_done_q && hold_cnt_q == EC_W'(ERASE_CYC - 1);
  assign wr_commit_o    = last && kind_q == PK_CODE;
  assign lock1_commit_o = last && kind_q == PK_LOCK1;
  assign lock2_commit_o = last && kind_q == PK_LOCK2;
  assign busy_o         = busy_q;
  assign pend_code_o    = kind_q == PK_CODE;
  assign pend_addr_o    = pend_addr_q;
  assign pend_data_o    = pend_data_q;
  assign ready_o        = ~busy_q && hold_cnt_q == '0;

  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q);

  // R9
  pend_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> $stable(pend_addr_q) && $stable(pend_data_q));

  // R5
  erase_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_commit_o |-> !busy_q && !wr_commit_o);
endmodule

// File: rtl/fp_array.sv
module fp_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              lock1_set_i,
  input  logic              lock2_set_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              lock1_o,
  output logic              lock2_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];
  logic       lock1_q, lock2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
    end else begin
      // programming only clears bits
      if (wr_i)        mem_q[wr_addr_i] <= mem_q[wr_addr_i] & wr_data_i;
      if (lock1_set_i) lock1_q <= 1'b1;
      if (lock2_set_i) lock2_q <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign lock1_o   = lock1_q;
  assign lock2_o   = lock2_q;

  // R2
  wr_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !erase_i |=> (mem_q[$past(wr_addr_i)] & ~$past(mem_q[wr_addr_i])) == 8'h00);

  // R5
  erase_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |=> mem_q[$past(rd_addr_i)] == 8'hFF && !lock1_q && !lock2_q);

  // R7
  lock1_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock1_q && !erase_i |=> lock1_q);
endmodule

// File: rtl/fp_read_mux.sv
module fp_read_mux
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  fp_op_e            op_i,
  input  logic              prog_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        rd_data_i,
  input  logic              lock2_i,
  input  logic              busy_i,
  input  logic              pend_code_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic [7:0]        pend_data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  logic [7:0] data_d, data_q;
  logic       oe_d, oe_q, poll_hit, sig_hit;

  assign poll_hit = busy_i && pend_code_i && addr_i == pend_addr_i;
  assign sig_hit  = (addr_i >> 2) == ADDR_W'(SIG_BASE >> 2);

  always_comb begin
    data_d = 8'hFF;
    oe_d   = 1'b0;
    if (prog_ni) begin
      if (op_i == OP_SIG) begin
        oe_d   = 1'b1;
        data_d = sig_hit ? sig_byte(addr_i[1:0]) : 8'hFF;
      end else if (op_i == OP_READ) begin
        oe_d = 1'b1;
        if (lock2_i)       data_d = 8'hFF;
        else if (poll_hit) data_d = {~pend_data_i[7], pend_data_i[6:0]};
        else               data_d = rd_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 8'hFF;
      oe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      oe_q   <= oe_d;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;

  // R8
  verify_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock2_i && op_i == OP_READ |=> data_q == 8'hFF);

  // R10
  oe_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_ni || (op_i != OP_READ && op_i != OP_SIG) |=> !oe_q);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WRITE_CYC = 150000,
  parameter int ERASE_CYC = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [3:0]        mode_i,
  input  logic              hv_en_i,
  input  logic              prog_ni,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              ready_o
);
  fp_op_e            op;
  logic              wr_c, l1_c, l2_c, er_c, busy, pend_code;
  logic              lock1, lock2;
  logic [ADDR_W-1:0] pend_addr;
  logic [7:0]        pend_data, rd_data;

  fp_mode_decode u_dec (.mode_i(mode_i), .op_o(op));

  fp_seq_timer #(
    .ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .hv_en_i(hv_en_i),
    .prog_ni(prog_ni), .lock1_i(lock1), .addr_i(addr_i), .data_i(data_i),
    .wr_commit_o(wr_c), .lock1_commit_o(l1_c), .lock2_commit_o(l2_c),
    .erase_commit_o(er_c), .busy_o(busy), .pend_code_o(pend_code),
    .pend_addr_o(pend_addr), .pend_data_o(pend_data), .ready_o(ready_o)
  );

  fp_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_c), .lock1_set_i(l1_c),
    .lock2_set_i(l2_c), .erase_i(er_c), .wr_addr_i(pend_addr),
    .wr_data_i(pend_data), .rd_addr_i(addr_i), .rd_data_o(rd_data),
    .lock1_o(lock1), .lock2_o(lock2)
  );

  fp_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .prog_ni(prog_ni),
    .addr_i(addr_i), .rd_data_i(rd_data), .lock2_i(lock2), .busy_i(busy),
    .pend_code_i(pend_code), .pend_addr_i(pend_addr), .pend_data_i(pend_data),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );
endmodule

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;
  localparam int AW = 10;
  localparam int WC = 8;
  localparam int EC = 20;
  localparam logic [3:0] M_IDLE = 4'b0000, M_WR = 4'b0001, M_RD = 4'b0010,
                         M_L1 = 4'b0100, M_L2 = 4'b0101, M_ER = 4'b1000,
                         M_SIG = 4'b1100, M_BAD = 4'b1111;

  // {addr, data, expected byte after write}
  localparam logic [25:0] VEC [6] = '{
    {10'h005, 8'hA5, 8'hA5},
    {10'h005, 8'h0F, 8'h05},
    {10'h3FF, 8'h3C, 8'h3C},
    {10'h000, 8'h00, 8'h00},
    {10'h030, 8'h7E, 8'h7E},
    {10'h005, 8'hFF, 8'h05}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic [3:0] mode = M_IDLE;
  logic hv = 1'b0, prog_n = 1'b1, oe, ready;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC)) i_flash_prog_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din), .mode_i(mode),
    .hv_en_i(hv), .prog_ni(prog_n), .data_o(dout), .data_oe_o(oe), .ready_o(ready)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act %0d cycles exp < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] m, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic h, output int lows);
    @(negedge clk); mode = m; addr = a; din = d; hv = h; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    lows = 0;
    for (int k = 0; k < WC + 4; k++) begin
      @(negedge clk);
      if (!ready) lows++;
    end
    mode = M_IDLE;
  endtask

  task automatic rd(input logic [3:0] m, input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); mode = m; addr = a; prog_n = 1'b1;
    @(negedge clk); v = dout;
  endtask

  task automatic erase(input int edges, output int low_mid);
    @(negedge clk); mode = M_ER; hv = 1'b1; prog_n = 1'b0;
    low_mid = 0;
    for (int k = 0; k < edges; k++) begin
      @(negedge clk);
      if (k == 2 && !ready) low_mid = 1;
    end
    prog_n = 1'b1;
    @(negedge clk); mode = M_IDLE;
  endtask

  initial begin
    logic [7:0] v;
    int lows, lm;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready === 1'b1, "R1 ready", ready, 1);
    check(oe === 1'b0, "R1 oe", oe, 0);
    rst_n = 1'b1;
    rd(M_RD, 10'h123, v);
    check(v === 8'hFF, "R1 erased", v, 8'hFF);

    // R2/R3 vector table
    for (int i = 0; i < 6; i++) begin
      pulse(M_WR, VEC[i][25:16], VEC[i][15:8], 1'b1, lows);
      check(lows == WC, "R3 busy length", lows, WC);
      rd(M_RD, VEC[i][25:16], v);
      check(v === VEC[i][7:0], "R2 and-write", v, VEC[i][7:0]);
    end

    // R4 polling
    @(negedge clk); mode = M_WR; addr = 10'h040; din = 8'h3C; hv = 1'b1; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    @(negedge clk); mode = M_RD;
    @(negedge clk);
    check(dout === 8'hBC && !ready, "R4 poll", dout, 8'hBC);
    check(oe === 1'b1, "R10 oe read", oe, 1);
    repeat (WC + 2) @(negedge clk);
    rd(M_RD, 10'h040, v);
    check(v === 8'h3C, "R4 done", v, 8'h3C);

    // R9 strobe while busy
    @(negedge clk); mode = M_WR; addr = 10'h041; din = 8'h00; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    @(negedge clk); addr = 10'h042; prog_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    repeat (WC + 4) @(negedge clk);
    rd(M_RD, 10'h041, v);
    check(v === 8'h00, "R9 first write", v, 0);
    rd(M_RD, 10'h042, v);
    check(v === 8'hFF, "R9 busy strobe ignored", v, 8'hFF);

    // R9 hv low, undefined mode
    pulse(M_WR, 10'h050, 8'h00, 1'b0, lows);
    rd(M_RD, 10'h050, v);
    check(lows == 0 && v === 8'hFF, "R9 hv low", v, 8'hFF);
    pulse(M_BAD, 10'h050, 8'h00, 1'b1, lows);
    rd(M_RD, 10'h050, v);
    check(lows == 0 && v === 8'hFF, "R9 bad mode", v, 8'hFF);

    // R10 oe gating
    @(negedge clk); mode = M_WR; prog_n = 1'b1;
    @(negedge clk);
    check(oe === 1'b0, "R10 oe write mode", oe, 0);
    @(negedge clk); mode = M_RD; prog_n = 1'b0; hv = 1'b0;
    @(negedge clk);
    check(oe === 1'b0, "R10 oe strobe low", oe, 0);
    prog_n = 1'b1; hv = 1'b1;

    // R6 identify
    rd(M_SIG, 10'h030, v); check(v === 8'h1E, "R6 sig0", v, 8'h1E);
    rd(M_SIG, 10'h031, v); check(v === 8'h62, "R6 sig1", v, 8'h62);
    rd(M_SIG, 10'h032, v); check(v === 8'hFF, "R6 sig2", v, 8'hFF);
    rd(M_SIG, 10'h005, v); check(v === 8'hFF, "R6 other", v, 8'hFF);

    // R5 short and full erase
    erase(EC - 1, lm);
    check(lm == 1, "R5 busy in hold", lm, 1);
    rd(M_RD, 10'h005, v); check(v === 8'h05, "R5 short hold", v, 8'h05);
    erase(EC, lm);
    rd(M_RD, 10'h005, v); check(v === 8'hFF, "R5 erased", v, 8'hFF);
    rd(M_RD, 10'h000, v); check(v === 8'hFF, "R5 erased 0", v, 8'hFF);

    // R7 lock 1
    pulse(M_L1, '0, '0, 1'b1, lows);
    check(lows == WC, "R7 lock write timed", lows, WC);
    pulse(M_WR, 10'h060, 8'h00, 1'b1, lows);
    check(lows == 0, "R7 write ready", lows, 0);
    rd(M_RD, 10'h060, v); check(v === 8'hFF, "R7 write blocked", v, 8'hFF);

    // R8 lock 2
    erase(EC, lm);
    pulse(M_WR, 10'h070, 8'h12, 1'b1, lows);
    pulse(M_L2, '0, '0, 1'b1, lows);
    rd(M_RD, 10'h070, v); check(v === 8'hFF, "R8 verify blocked", v, 8'hFF);
    rd(M_SIG, 10'h031, v); check(v === 8'h62, "R8 sig allowed", v, 8'h62);

    // R5 erase clears protection
    erase(EC, lm);
    pulse(M_WR, 10'h070, 8'h34, 1'b1, lows);
    rd(M_RD, 10'h070, v); check(v === 8'h34, "R5 locks cleared", v, 8'h34);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule